// File: doc/BRIEF.md
# Interval Timer with Deadline Alarm

This block keeps a wide free-running count of a fast base tick and presents a slower view of it to software. The visible count advances once for every four base ticks, so a read returns the base count with its two lowest bits dropped. Only 32 bits of that view are readable, which are base bits 33 down to 2. A read strobe captures the view into an output register, and that register holds its value until the next read.

Software arms an alarm by writing a 32-bit compare value. The write widens the value into a deadline in the 34-bit base-tick domain. The written value is shifted left by two and replaces the low 34 bits of the current base count, while the upper base bits are kept. A deadline that lands less than a guard distance of 1000 base ticks ahead of the current count, including one that is already in the past, is moved forward by one full 34-bit wrap. When the base count reaches the armed deadline, the block emits a single-cycle alarm pulse and disarms until software writes again. Masking of the interrupt belongs to the interrupt controller and is not part of this block.

Top module: `interval_alarm_timer`

## Requirements
- R1: After a synchronous reset `count_rd` reads 0, `alarm` is low, and the comparator is disarmed. The disarmed comparator raises no pulse, even though the cleared base count equals the cleared deadline.
- R2: The internal 64-bit base count increases by exactly one on each clock where `tick_en` is high and keeps its value on every other clock.
- R3: A clock with `rd_en` high loads `count_rd` with base bits [33:2], taken from the count present in that cycle. The new value is visible after that clock edge. Without `rd_en`, `count_rd` keeps its value.
- R4: A write forms a deadline that keeps base bits [63:34] of the current count and sets bits [33:0] to `{wr_data, 2'b00}`.
- R5: When the formed deadline is smaller than the current base count plus 1000, the armed deadline is the formed value plus 2^34. A deadline of exactly the current count plus 1000 is armed as formed.
- R6: `alarm` is high for exactly one clock. It rises on the clock edge that ends the first cycle in which the comparator is armed and the base count is at or above the deadline.
- R7: A write produces at most one pulse. After the pulse the comparator stays disarmed until the next write.
- R8: A write replaces any pending deadline. When a write arrives in the same cycle as a fire condition, the write takes effect and no pulse is produced for the old deadline.
- R9: Asserting `rst` while the comparator is armed cancels the alarm and clears the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Base tick enable, one base tick per high clock |
| rd_en | input | 1 | Capture the visible count into `count_rd` |
| wr_en | input | 1 | Arm the comparator with `wr_data` |
| wr_data | input | 32 | Compare value in visible-count units |
| count_rd | output | 32 | Captured visible count (base bits [33:2]) |
| alarm | output | 1 | Single-cycle alarm pulse |

## Verification
Every result here is one register away from its cause. A read is visible in `count_rd` on the edge that samples `rd_en`. A tick shows up in the next read. A pulse appears on the edge that ends the first cycle in which the armed deadline is met. The bench changes inputs on the falling edge and samples two nanoseconds after the rising edge. It updates its reference count, armed flag and deadline in step with each edge, from the values in force before that edge, so every comparison falls in the cycle in which the output is due. The directed cases cover the boundary at exactly 1000 ticks ahead and one step below it, a write that lands on a fire cycle, and a reset while the comparator is armed.

// File: rtl/iat_pkg.sv
package iat_pkg;

    localparam int unsigned IAT_BASE_W  = 64;
    localparam int unsigned IAT_CMP_W   = 32;
    localparam int unsigned IAT_PRE_SH  = 2;
    localparam int unsigned IAT_GUARD   = 1000;

    typedef enum logic [1:0] {
        EVT_IDLE = 2'd0,
        EVT_LOAD = 2'd1,
        EVT_FIRE = 2'd2
    } alarm_evt_e;

    function automatic alarm_evt_e pick_event(input logic wr, input logic armed,
                                              input logic reached);
        alarm_evt_e e;
        if (wr)                   e = EVT_LOAD;
        else if (armed && reached) e = EVT_FIRE;
        else                       e = EVT_IDLE;
        return e;
    endfunction

endpackage

// File: rtl/iat_base_counter.sv
module iat_base_counter #(
    parameter int unsigned CNT_W = iat_pkg::IAT_BASE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_en,
    output logic [CNT_W-1:0] base_q
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst)          base_q <= '0;
        else if (tick_en) base_q <= base_q + ONE;
    end

    p_advance_r2: assert property (@(posedge clk) disable iff (rst)
        tick_en |=> base_q == $past(base_q) + ONE);
    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !tick_en |=> $stable(base_q));

endmodule

// File: rtl/iat_deadline_calc.sv
module iat_deadline_calc #(
    parameter int unsigned CNT_W = iat_pkg::IAT_BASE_W,
    parameter int unsigned CMP_W = iat_pkg::IAT_CMP_W,
    parameter int unsigned SHIFT = iat_pkg::IAT_PRE_SH,
    parameter int unsigned GUARD = iat_pkg::IAT_GUARD
) (
    input  logic [CNT_W-1:0] base_i,
    input  logic [CMP_W-1:0] wr_data,
    output logic [CNT_W-1:0] deadline_o
);
    localparam int unsigned DL_W = CMP_W + SHIFT;
    localparam logic [CNT_W-1:0] GUARD_V = CNT_W'(GUARD);

    logic [DL_W-1:0]  low_part;
    logic [CNT_W-1:0] formed;
    logic [CNT_W-1:0] limit;

    assign low_part = {wr_data, {SHIFT{1'b0}}};
    assign limit    = base_i + GUARD_V;

    generate
        if (CNT_W > DL_W) begin : g_wide
            localparam logic [CNT_W-1:0] WRAP = CNT_W'(1) << DL_W;
            assign formed = {base_i[CNT_W-1:DL_W], low_part};
            always_comb begin
                deadline_o = formed;
                if (formed < limit) deadline_o = formed + WRAP;
            end
        end else begin : g_narrow
            assign formed     = low_part[CNT_W-1:0];
            assign deadline_o = formed;
        end
    endgenerate

endmodule

// File: rtl/iat_alarm_ctrl.sv
module iat_alarm_ctrl #(
    parameter int unsigned CNT_W = iat_pkg::IAT_BASE_W,
    parameter int unsigned CMP_W = iat_pkg::IAT_CMP_W,
    parameter int unsigned SHIFT = iat_pkg::IAT_PRE_SH,
    parameter int unsigned GUARD = iat_pkg::IAT_GUARD
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [CMP_W-1:0] wr_data,
    input  logic [CNT_W-1:0] base_i,
    input  logic [CNT_W-1:0] deadline_new,
    output logic             alarm_q
);
    import iat_pkg::*;

    localparam int unsigned DL_W = CMP_W + SHIFT;
    localparam logic [CNT_W-1:0] GUARD_V = CNT_W'(GUARD);

    logic             armed_q;
    logic [CNT_W-1:0] deadline_q;
    logic             reached;
    alarm_evt_e       evt;

    assign reached = base_i >= deadline_q;
    assign evt     = pick_event(wr_en, armed_q, reached);

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q    <= 1'b0;
            deadline_q <= '0;
            alarm_q    <= 1'b0;
        end else begin
            alarm_q <= 1'b0;
            unique case (evt)
                EVT_LOAD: begin
                    armed_q    <= 1'b1;
                    deadline_q <= deadline_new;
                end
                EVT_FIRE: begin
                    armed_q <= 1'b0;
                    alarm_q <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    p_pulse_width_r6: assert property (@(posedge clk) disable iff (rst)
        alarm_q |=> !alarm_q);
    p_fire_reached_r6: assert property (@(posedge clk) disable iff (rst)
        alarm_q |-> $past(base_i >= deadline_q));
    p_fire_armed_r7: assert property (@(posedge clk) disable iff (rst)
        alarm_q |-> !armed_q && $past(armed_q));
    p_write_wins_r8: assert property (@(posedge clk) disable iff (rst)
        alarm_q |-> !$past(wr_en));
    p_low_bits_r4: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> deadline_q[DL_W-1:0] == {$past(wr_data), {SHIFT{1'b0}}}
                  && armed_q);
    p_guard_r5: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> deadline_q >= $past(base_i) + GUARD_V);

endmodule

// File: rtl/iat_readback.sv
module iat_readback #(
    parameter int unsigned CMP_W = iat_pkg::IAT_CMP_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rd_en,
    input  logic [CMP_W-1:0] view_i,
    output logic [CMP_W-1:0] count_q
);
    always_ff @(posedge clk) begin
        if (rst)        count_q <= '0;
        else if (rd_en) count_q <= view_i;
    end

    p_capture_r3: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> count_q == $past(view_i));
    p_keep_r3: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(count_q));

endmodule

// File: rtl/interval_alarm_timer.sv
module interval_alarm_timer #(
    parameter int unsigned CNT_W = iat_pkg::IAT_BASE_W,
    parameter int unsigned CMP_W = iat_pkg::IAT_CMP_W,
    parameter int unsigned SHIFT = iat_pkg::IAT_PRE_SH,
    parameter int unsigned GUARD = iat_pkg::IAT_GUARD
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_en,
    input  logic             rd_en,
    input  logic             wr_en,
    input  logic [CMP_W-1:0] wr_data,
    output logic [CMP_W-1:0] count_rd,
    output logic             alarm
);
    localparam int unsigned DL_W = CMP_W + SHIFT;

    logic [CNT_W-1:0] base_q;
    logic [CNT_W-1:0] deadline_new;

    iat_base_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .tick_en (tick_en),
        .base_q  (base_q)
    );

    iat_deadline_calc #(.CNT_W(CNT_W), .CMP_W(CMP_W), .SHIFT(SHIFT), .GUARD(GUARD)) u_calc (
        .base_i     (base_q),
        .wr_data    (wr_data),
        .deadline_o (deadline_new)
    );

    iat_alarm_ctrl #(.CNT_W(CNT_W), .CMP_W(CMP_W), .SHIFT(SHIFT), .GUARD(GUARD)) u_alarm (
        .clk          (clk),
        .rst          (rst),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .base_i       (base_q),
        .deadline_new (deadline_new),
        .alarm_q      (alarm)
    );

    iat_readback #(.CMP_W(CMP_W)) u_rd (
        .clk     (clk),
        .rst     (rst),
        .rd_en   (rd_en),
        .view_i  (base_q[DL_W-1:SHIFT]),
        .count_q (count_rd)
    );

endmodule

// File: tb/interval_alarm_timer_bench.sv
`timescale 1ns/1ps
module interval_alarm_timer_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_en = 1'b0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] count_rd;
    logic        alarm;

    always #5 clk = ~clk;

    interval_alarm_timer u_interval_alarm_timer (
        .clk(clk), .rst(rst), .tick_en(tick_en), .rd_en(rd_en),
        .wr_en(wr_en), .wr_data(wr_data), .count_rd(count_rd), .alarm(alarm)
    );

    int unsigned n_chk = 0;
    int unsigned n_bad = 0;

    logic [63:0] mb = '0;
    logic [63:0] m_dl = '0;
    bit          m_armed = 1'b0;
    logic        exp_alarm = 1'b0;
    logic [31:0] exp_cnt = '0;

    function automatic logic [63:0] dl_of(input logic [63:0] b, input logic [31:0] w);
        logic [63:0] d;
        d = {b[63:34], w, 2'b00};
        if (d < b + 64'd1000) d = d + (64'd1 << 34);
        return d;
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic step(input bit r, input bit te, input bit rd, input bit wr,
                        input logic [31:0] d, input string tag);
        @(negedge clk);
        rst = r; tick_en = te; rd_en = rd; wr_en = wr; wr_data = d;
        @(posedge clk);
        if (r) begin
            mb = '0; m_armed = 1'b0; exp_alarm = 1'b0; exp_cnt = '0;
        end else begin
            exp_alarm = 1'b0;
            if (wr) begin
                m_dl = dl_of(mb, d); m_armed = 1'b1;
            end else if (m_armed && mb >= m_dl) begin
                exp_alarm = 1'b1; m_armed = 1'b0;
            end
            if (rd) exp_cnt = mb[33:2];
            if (te) mb = mb + 64'd1;
        end
        #2;
        check(tag, "alarm", {63'd0, alarm}, {63'd0, exp_alarm});
        check(tag, "count_rd", {32'd0, count_rd}, {32'd0, exp_cnt});
    endtask

    task automatic ticks(input int n, input string tag);
        for (int i = 0; i < n; i++) step(1'b0, 1'b1, 1'b0, 1'b0, '0, tag);
    endtask

    task automatic align4(input string tag);
        while (((mb + 64'd1000) % 64'd4) != 0) step(1'b0, 1'b1, 1'b0, 1'b0, '0, tag);
    endtask

    task automatic run_to_fire(input string tag);
        int guard = 0;
        while (!(m_armed && mb >= m_dl) && guard < 20000) begin
            step(1'b0, 1'b1, 1'b0, 1'b0, '0, tag);
            guard++;
        end
        step(1'b0, 1'b1, 1'b0, 1'b0, '0, tag);
        check(tag, "fired", {63'd0, alarm}, 64'd1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        int unsigned seed;
        logic [31:0] w;
        seed = $urandom(32'd20240611);

        // R1: reset state, no pulse though deadline and count are both zero
        for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 1'b1, 1'b0, '0, "R1");
        for (int i = 0; i < 5; i++) step(1'b0, 1'b0, 1'b0, 1'b0, '0, "R1");
        step(1'b0, 1'b0, 1'b1, 1'b0, '0, "R1");

        // R2: count moves only with tick_en
        ticks(37, "R2");
        step(1'b0, 1'b0, 1'b1, 1'b0, '0, "R2");
        for (int i = 0; i < 10; i++) step(1'b0, 1'b0, 1'b0, 1'b0, '0, "R2");
        step(1'b0, 1'b1, 1'b1, 1'b0, '0, "R2");

        // R3: readback holds without rd_en, then captures
        ticks(50, "R3");
        step(1'b0, 1'b1, 1'b1, 1'b0, '0, "R3");

        // R5: deadline exactly guard ahead is kept and fires
        align4("R5");
        step(1'b0, 1'b0, 1'b0, 1'b1, 32'((mb + 64'd1000) >> 2), "R5");
        run_to_fire("R5");
        // R6/R7: single pulse, then silent
        ticks(5, "R6");
        ticks(2000, "R7");

        // R5: one visible step below the guard wraps, no pulse
        align4("R5");
        step(1'b0, 1'b0, 1'b0, 1'b1, 32'((mb + 64'd996) >> 2), "R5");
        ticks(3000, "R5");
        // R5: zero written after count has advanced wraps too
        step(1'b0, 1'b1, 1'b0, 1'b1, 32'd0, "R5");
        ticks(1500, "R5");

        // R4: low bits come from written value, upper from count
        w = 32'(mb >> 2) + 32'd400;
        step(1'b0, 1'b1, 1'b0, 1'b1, w, "R4");
        run_to_fire("R4");
        ticks(3, "R4");

        // R8: a newer write replaces a far deadline
        step(1'b0, 1'b1, 1'b0, 1'b1, 32'(mb >> 2) + 32'd5000, "R8");
        ticks(100, "R8");
        step(1'b0, 1'b1, 1'b0, 1'b1, 32'(mb >> 2) + 32'd300, "R8");
        run_to_fire("R8");
        // R8: write on the fire cycle suppresses the old pulse
        step(1'b0, 1'b1, 1'b0, 1'b1, 32'(mb >> 2) + 32'd260, "R8");
        while (!(m_armed && mb >= m_dl)) step(1'b0, 1'b1, 1'b0, 1'b0, '0, "R8");
        step(1'b0, 1'b1, 1'b0, 1'b1, 32'(mb >> 2) + 32'd270, "R8");
        check("R8", "no pulse on write", {63'd0, alarm}, 64'd0);
        run_to_fire("R8");

        // R9: reset while armed cancels alarm
        step(1'b0, 1'b1, 1'b0, 1'b1, 32'(mb >> 2) + 32'd300, "R9");
        ticks(100, "R9");
        step(1'b1, 1'b1, 1'b0, 1'b0, '0, "R9");
        ticks(2500, "R9");
        step(1'b0, 1'b1, 1'b1, 1'b0, '0, "R9");

        // R6: random mix
        for (int i = 0; i < 8000; i++) begin
            bit te, rd, wr;
            te = ($urandom % 4) != 0;
            rd = ($urandom % 10) < 3;
            wr = ($urandom % 200) == 0;
            if ($urandom % 3 == 0) w = $urandom;
            else w = 32'(mb >> 2) + ($urandom % 700);
            step(1'b0, te, rd, wr, w, "R6");
        end

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule